// File: doc/BRIEF.md
# Interrupt Request Control Register Unit

This block keeps the processor-side interrupt bookkeeping that sits between the interrupt sources and the CPU core. It holds one 8-bit control register and a bank of per-source interrupt control registers. Each of those has a pending-request flag that hardware events raise and that the core clears by accepting the interrupt. Software writes to the pending flags are blocked unless a global software-write enable in the control register is set. With the enable clear, a read-modify-write of an interrupt control register cannot wipe out a request that arrived between its read and its write.

When the core accepts an interrupt, it presents the source index on an accept strobe. The block clears that source's pending flag and loads the master interrupt enable from a nesting bit: it is cleared for non-nested operation and set to allow nesting. A further control bit picks one of two vector table base addresses for the core's vector fetch.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After reset the control register (address 0) reads 0x01, every pending flag and enable flag is 0, `mie` is 0 and `vec_base` is 0x04000.
- R2: Control bit 6 selects the vector base: 0 gives `vec_base` = 0x04000 and 1 gives 0x00100, from the cycle after the write.
- R3: Control bits 7, 3 and 1 always read 0 and ignore writes. Bits 5 and 4 are stored and read back as written. Writing 0xFF to the control register reads back 0x75.
- R4: While control bit 2 is 0, a register write to interrupt control register i (address i+1) leaves its pending flag (bit 0) unchanged. Its enable flag (bit 1) is still written.
- R5: While control bit 2 is 1, a register write to interrupt control register i loads its pending flag from write-data bit 0.
- R6: An asserted `irq_evt[i]` sets pending flag i in the next cycle. It wins over an enabled software write of 0 in the same cycle.
- R7: `acc_valid` with `acc_src` = i clears pending flag i in the next cycle. If `irq_evt[i]` is asserted in the same cycle, the flag stays set.
- R8: On `acc_valid`, `mie` takes the value of control bit 0 in the next cycle: 0 clears it and 1 sets it.
- R9: `cpu_mie_wr` loads `mie` from `cpu_mie_val` in the next cycle. An accept in the same cycle takes priority.
- R10: Interrupt control registers read back with pending in bit 0, enable in bit 1 and 0 in all other bits. Addresses above the last source read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 4 | Register address: 0 control, i+1 source i |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_evt | input | 8 | Hardware interrupt events, one per source |
| acc_valid | input | 1 | Interrupt accept strobe |
| acc_src | input | 3 | Index of the accepted source |
| cpu_mie_wr | input | 1 | Core write of the master interrupt enable |
| cpu_mie_val | input | 1 | Value for the core write |
| mie | output | 1 | Master interrupt enable |
| vec_base | output | 20 | Vector table base address |
| irq_pend | output | 8 | Pending flags |
| irq_en | output | 8 | Per-source enable flags |

## Verification
The in-line assertions check the following on every cycle:
- an event always leaves the pending flag set;
- a blocked write never moves the flag;
- an accepted source's flag drops unless a new event arrives;
- `mie` follows the nesting bit after each accept;
- the vector base follows bit 6 after each control write.

Some behaviours can only be shown by the bench's scenarios, because they depend on address decode and readback:
- the masking of the reserved control bits;
- the readback layout of the source registers;
- the zero read of unmapped addresses;
- the exact reset values.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int DATA_W = 8;
  localparam int VEC_W  = 20;

  localparam logic [VEC_W-1:0] VEC_BASE_HIGH = 20'h04000;
  localparam logic [VEC_W-1:0] VEC_BASE_LOW  = 20'h00100;

  localparam int CB_VSEL  = 6;
  localparam int CB_SPR_H = 5;
  localparam int CB_SPR_L = 4;
  localparam int CB_SWE   = 2;
  localparam int CB_NEST  = 0;

  localparam int IB_REQ = 0;
  localparam int IB_EN  = 1;

  typedef struct packed {
    logic       vsel;
    logic [1:0] spare;
    logic       swe;
    logic       nest;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{vsel: 1'b0, spare: 2'b00, swe: 1'b0, nest: 1'b1};
endpackage

// File: rtl/irq_ctl_ctrlreg.sv
module irq_ctl_ctrlreg
  import irq_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output ctl_t              ctl,
  output logic [DATA_W-1:0] rdata
);
  ctl_t ctl_q, ctl_d;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[7], wdata[3], wdata[1]};

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d.vsel  = wdata[CB_VSEL];
      ctl_d.spare = wdata[CB_SPR_H:CB_SPR_L];
      ctl_d.swe   = wdata[CB_SWE];
      ctl_d.nest  = wdata[CB_NEST];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= CTL_RESET;
    else if (wr_en) ctl_q <= ctl_d;
  end

  always_comb begin
    rdata                    = '0;
    rdata[CB_VSEL]           = ctl_q.vsel;
    rdata[CB_SPR_H:CB_SPR_L] = ctl_q.spare;
    rdata[CB_SWE]            = ctl_q.swe;
    rdata[CB_NEST]           = ctl_q.nest;
  end

  assign ctl = ctl_q;

  assert_ctl_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdata[CB_SPR_H:CB_SPR_L] == $past(wdata[CB_SPR_H:CB_SPR_L])));
endmodule

// File: rtl/irq_ctl_icr.sv
module irq_ctl_icr
  import irq_ctl_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              swe,
  input  logic [DATA_W-1:0] wdata,
  input  logic              evt,
  input  logic              acc_valid,
  input  logic [IDX_W-1:0]  acc_src,
  output logic              pend,
  output logic              en,
  output logic [DATA_W-1:0] rdata
);
  logic pend_q, pend_d, en_q, en_d, acc_hit, upd;
  logic unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-1:2];
  assign acc_hit      = acc_valid && (acc_src == IDX_W'(IDX));
  assign upd          = wr_en || acc_hit || evt;

  always_comb begin
    pend_d = pend_q;
    en_d   = en_q;
    if (wr_en) begin
      en_d = wdata[IB_EN];
      if (swe) pend_d = wdata[IB_REQ];
    end
    if (acc_hit) pend_d = 1'b0;
    if (evt)     pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (upd) begin
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end

  assign pend = pend_q;
  assign en   = en_q;

  always_comb begin
    rdata         = '0;
    rdata[IB_REQ] = pend_q;
    rdata[IB_EN]  = en_q;
  end

  assert_blocked_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !swe && !evt && !acc_hit) |=> (pend == $past(pend)));
  assert_open_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && swe && !evt && !acc_hit) |=> (pend == $past(wdata[IB_REQ])));
  assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pend);
  assert_accept_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && !evt) |=> !pend);
endmodule

// File: rtl/irq_ctl_mie.sv
module irq_ctl_mie (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_valid,
  input  logic nest,
  input  logic cpu_wr,
  input  logic cpu_val,
  output logic mie
);
  logic mie_q, mie_d, upd;

  assign upd = acc_valid || cpu_wr;

  always_comb begin
    mie_d = mie_q;
    if (cpu_wr)    mie_d = cpu_val;
    if (acc_valid) mie_d = nest;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mie_q <= 1'b0;
    else if (upd) mie_q <= mie_d;
  end

  assign mie = mie_q;

  assert_accept_mie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (mie == $past(nest)));
  assert_cpu_mie_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !acc_valid) |=> (mie == $past(cpu_val)));
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
  import irq_ctl_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 4,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] irq_evt,
  input  logic               acc_valid,
  input  logic [IDX_W-1:0]   acc_src,
  input  logic               cpu_mie_wr,
  input  logic               cpu_mie_val,
  output logic               mie,
  output logic [VEC_W-1:0]   vec_base,
  output logic [NUM_SRC-1:0] irq_pend,
  output logic [NUM_SRC-1:0] irq_en
);
  logic [1:0]        rst_sync;
  logic              rst_i_n;
  logic              ctl_wr;
  ctl_t              ctl;
  logic [DATA_W-1:0] ctl_rd;
  logic [DATA_W-1:0] icr_rd [NUM_SRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  assign ctl_wr = reg_wr && (reg_addr == '0);

  irq_ctl_ctrlreg u_ctrl (
    .clk  (clk),
    .rst_n(rst_i_n),
    .wr_en(ctl_wr),
    .wdata(reg_wdata),
    .ctl  (ctl),
    .rdata(ctl_rd)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic icr_wr;
    assign icr_wr = reg_wr && (reg_addr == ADDR_W'(i + 1));
    irq_ctl_icr #(.IDX(i), .IDX_W(IDX_W)) u_icr (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .wr_en    (icr_wr),
      .swe      (ctl.swe),
      .wdata    (reg_wdata),
      .evt      (irq_evt[i]),
      .acc_valid(acc_valid),
      .acc_src  (acc_src),
      .pend     (irq_pend[i]),
      .en       (irq_en[i]),
      .rdata    (icr_rd[i])
    );
  end

  irq_ctl_mie u_mie (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .acc_valid(acc_valid),
    .nest     (ctl.nest),
    .cpu_wr   (cpu_mie_wr),
    .cpu_val  (cpu_mie_val),
    .mie      (mie)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata = ctl_rd;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reg_addr == ADDR_W'(i + 1)) reg_rdata = icr_rd[i];
    end
  end

  assign vec_base = ctl.vsel ? VEC_BASE_LOW : VEC_BASE_HIGH;

  assert_vec_base_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    ctl_wr |=> (vec_base == ($past(reg_wdata[CB_VSEL]) ? VEC_BASE_LOW : VEC_BASE_HIGH)));
endmodule

// File: tb/test_irq_ctrl_unit.sv
`timescale 1ns/1ps
module test_irq_ctrl_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [7:0]  irq_evt;
  logic        acc_valid;
  logic [2:0]  acc_src;
  logic        cpu_mie_wr, cpu_mie_val;
  logic        mie;
  logic [19:0] vec_base;
  logic [7:0]  irq_pend, irq_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  irq_ctrl_unit i_irq_ctrl_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_evt(irq_evt),
    .acc_valid(acc_valid), .acc_src(acc_src), .cpu_mie_wr(cpu_mie_wr),
    .cpu_mie_val(cpu_mie_val), .mie(mie), .vec_base(vec_base),
    .irq_pend(irq_pend), .irq_en(irq_en)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 0; reg_addr = 0; reg_wdata = 0; irq_evt = 0;
    acc_valid = 0; acc_src = 0; cpu_mie_wr = 0; cpu_mie_val = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(4'd0, d);
    chk("R1 ctrl", {24'd0, d}, 32'h01);
    chk("R1 pend", {24'd0, irq_pend}, 32'h0);
    chk("R1 en", {24'd0, irq_en}, 32'h0);
    chk("R1 mie", {31'd0, mie}, 32'h0);
    chk("R1 vec", {12'd0, vec_base}, 32'h04000);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    wr(4'd0, 8'hFF);
    rd(4'd0, d);
    chk("R3 mask", {24'd0, d}, 32'h75);
    chk("R2 vec1", {12'd0, vec_base}, 32'h00100);
    wr(4'd0, 8'h8A);
    rd(4'd0, d);
    chk("R3 ignore", {24'd0, d}, 32'h00);
    chk("R2 vec0", {12'd0, vec_base}, 32'h04000);
  endtask

  task automatic t_blocked();
    logic [7:0] d;
    @(negedge clk); irq_evt = 8'h04; step();
    rd(4'd3, d);
    chk("R6 set", {24'd0, d}, 32'h01);
    wr(4'd3, 8'h02);
    rd(4'd3, d);
    chk("R4 keep req, write en", {24'd0, d}, 32'h03);
    wr(4'd3, 8'h00);
    chk("R4 keep req", {31'd0, irq_pend[2]}, 32'h1);
    wr(4'd7, 8'h01);
    chk("R4 no set", {31'd0, irq_pend[6]}, 32'h0);
  endtask

  task automatic t_open();
    logic [7:0] d;
    wr(4'd0, 8'h04);
    wr(4'd3, 8'h00);
    rd(4'd3, d);
    chk("R5 clear", {24'd0, d}, 32'h00);
    wr(4'd4, 8'h01);
    chk("R5 set", {31'd0, irq_pend[3]}, 32'h1);
    wr(4'd5, 8'h01);
    @(negedge clk);
    reg_wr = 1; reg_addr = 4'd5; reg_wdata = 8'h00; irq_evt = 8'h10;
    step();
    chk("R6 evt beats sw 0", {31'd0, irq_pend[4]}, 32'h1);
  endtask

  task automatic t_accept();
    @(negedge clk); acc_valid = 1; acc_src = 3'd3; step();
    chk("R7 clear", {31'd0, irq_pend[3]}, 32'h0);
    chk("R7 others", {31'd0, irq_pend[4]}, 32'h1);
    @(negedge clk); acc_valid = 1; acc_src = 3'd4; irq_evt = 8'h10; step();
    chk("R7 evt wins", {31'd0, irq_pend[4]}, 32'h1);
  endtask

  task automatic t_mie();
    @(negedge clk); cpu_mie_wr = 1; cpu_mie_val = 1; step();
    chk("R9 cpu set", {31'd0, mie}, 32'h1);
    @(negedge clk); acc_valid = 1; acc_src = 3'd0; step();
    chk("R8 nest0 clears", {31'd0, mie}, 32'h0);
    wr(4'd0, 8'h05);
    @(negedge clk); acc_valid = 1; acc_src = 3'd1; step();
    chk("R8 nest1 sets", {31'd0, mie}, 32'h1);
    @(negedge clk); acc_valid = 1; cpu_mie_wr = 1; cpu_mie_val = 0; step();
    chk("R9 accept priority", {31'd0, mie}, 32'h1);
    @(negedge clk); cpu_mie_wr = 1; cpu_mie_val = 0; step();
    chk("R9 cpu clear", {31'd0, mie}, 32'h0);
  endtask

  task automatic t_map();
    logic [7:0] d;
    wr(4'd8, 8'hFF);
    rd(4'd8, d);
    chk("R10 layout", {24'd0, d}, 32'h03);
    chk("R10 en7", {31'd0, irq_en[7]}, 32'h1);
    for (int a = 9; a < 16; a++) begin
      rd(4'(a), d);
      chk("R10 unmapped", {24'd0, d}, 32'h00);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ctrl();
    t_blocked();
    t_open();
    t_accept();
    t_mie();
    t_map();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule